// File: doc/BRIEF.md
# Operand Read-Port Request Generator

This block serves one ALU function unit. It takes the decoded record of the current instruction and works out which of the unit's four operand ports the instruction really needs. The four ports are integer RA, integer RB, the XER summary-overflow bit and the XER carry pair. For each port it drives a valid flag and a read-select vector toward the register file that holds that operand. Integer registers are selected in unary (one-hot) form over the register file. XER operands are selected as a bit mask over the 64-bit XER.

The valid flags and select vectors follow the decoded record combinationally. Read requests are registered. A small two-state machine per port raises the port's request in the cycle after an issue strobe that finds the port needed. It holds the request until that port's acknowledge is seen.

States of each port machine:
- `ST_IDLE`: no request is pending.
- `ST_WAIT`: a request is pending.

Transitions of each port machine:
- LAUNCH, from `ST_IDLE` to `ST_WAIT`: taken when issue and need are both high.
- RETIRE, from `ST_WAIT` to `ST_IDLE`: taken when ack is high.
- All other combinations hold the current state.

Top module: `opreq_gen`

## Requirements
- R1: `ra_valid` equals `rd1_ok`. `ra_sel` is one-hot with bit `rd1_num` set while `ra_valid` is high.
- R2: `rb_valid` equals `rd2_ok` AND NOT `imm_sel`. `rb_sel` is one-hot with bit `rd2_num` set while `rb_valid` is high.
- R3: While `imm_sel` is high, `rb_valid` is low, `rb_sel` is zero, and an issue raises no RB request (`req[1]`).
- R4: `so_valid` equals `oe`. `so_sel` has only bit 32 set while `so_valid` is high.
- R5: `ca_valid` equals `carry_use`. `ca_sel` has exactly bits 34 and 45 set while `ca_valid` is high.
- R6: Every select vector is all-zero while its valid flag is low.
- R7: `req` bit order is 0=RA, 1=RB, 2=SO, 3=CA. A request bit rises in the cycle after an issue that finds its port valid, and only then. An instruction that needs only RA (such as a negate) raises `req[0]` alone.
- R8: A raised request stays high until its `ack` bit is sampled high. It is low in the cycle after that.
- R9: An issue that finds a port's request still pending is ignored for that port, so a single acknowledge retires it. An `ack` on a port with no pending request has no effect.
- R10: After reset all request bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue | input | 1 | Issue strobe for the current decoded instruction |
| rd1_ok | input | 1 | Decoder: first read register needed |
| rd1_num | input | 5 | Decoder: first read register number |
| rd2_ok | input | 1 | Decoder: second read register needed |
| rd2_num | input | 5 | Decoder: second read register number |
| imm_sel | input | 1 | Second operand is an immediate |
| oe | input | 1 | Instruction records overflow (needs SO) |
| carry_use | input | 1 | Instruction consumes carry (needs CA/CA32) |
| ack | input | 4 | Per-port request acknowledge |
| ra_valid | output | 1 | RA operand needed |
| ra_sel | output | 32 | One-hot integer read select for RA |
| rb_valid | output | 1 | RB operand needed |
| rb_sel | output | 32 | One-hot integer read select for RB |
| so_valid | output | 1 | SO operand needed |
| so_sel | output | 64 | XER bit mask for SO |
| ca_valid | output | 1 | Carry operand needed |
| ca_sel | output | 64 | XER bit mask for CA and CA32 |
| req | output | 4 | Registered per-port read requests |

## Verification
The bench builds the block with its defaults: a 32-entry integer file, a 64-bit XER, SO at bit 32, and carry at bits 34 and 45. With those values, register numbers at both ends of the file (0 and 31) are reached, as are the exact XER bit positions. All four ports also run their request machines side by side. This puts within reach partial acknowledges, issues that arrive while a port is still pending, and acknowledges sent to idle ports.

// File: rtl/opreq_pkg.sv
package opreq_pkg;
    localparam int NUM_PORTS = 4;
    localparam int P_RA = 0;
    localparam int P_RB = 1;
    localparam int P_SO = 2;
    localparam int P_CA = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } port_state_t;
endpackage

// File: rtl/opreq_decode.sv
module opreq_decode #(
    parameter int REG_NUM  = 32,
    parameter int XER_W    = 64,
    parameter int SO_BIT   = 32,
    parameter int CA_BIT   = 34,
    parameter int CA32_BIT = 45,
    localparam int IDX_W   = $clog2(REG_NUM)
) (
    input  logic               rd1_ok,
    input  logic [IDX_W-1:0]   rd1_num,
    input  logic               rd2_ok,
    input  logic [IDX_W-1:0]   rd2_num,
    input  logic               imm_sel,
    input  logic               oe,
    input  logic               carry_use,
    output logic [3:0]         need,
    output logic [REG_NUM-1:0] ra_sel,
    output logic [REG_NUM-1:0] rb_sel,
    output logic [XER_W-1:0]   so_sel,
    output logic [XER_W-1:0]   ca_sel
);
    localparam logic [XER_W-1:0] SO_MASK = XER_W'(1) << SO_BIT;
    localparam logic [XER_W-1:0] CA_MASK = (XER_W'(1) << CA_BIT) | (XER_W'(1) << CA32_BIT);

    logic ra_need, rb_need, so_need, ca_need;

    always_comb begin
        ra_need = rd1_ok;
        rb_need = rd2_ok & ~imm_sel;
        so_need = oe;
        ca_need = carry_use;
        need    = {ca_need, so_need, rb_need, ra_need};
        ra_sel  = ra_need ? (REG_NUM'(1) << rd1_num) : '0;
        rb_sel  = rb_need ? (REG_NUM'(1) << rd2_num) : '0;
        so_sel  = so_need ? SO_MASK : '0;
        ca_sel  = ca_need ? CA_MASK : '0;
    end
endmodule

// File: rtl/opreq_port_fsm.sv
module opreq_port_fsm
    import opreq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic need,
    input  logic ack,
    output logic req
);
    port_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (issue && need) state_d = ST_WAIT;  // LAUNCH
            ST_WAIT: if (ack)           state_d = ST_IDLE;  // RETIRE
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_WAIT: req = 1'b1;
            default: req = 1'b0;
        endcase
    end

    AST_REQ_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req) |-> $past(issue && need));  // R7
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && !(issue && need)) |=> !req);  // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack) |=> req);  // R8
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ack) |=> !req);  // R8
endmodule

// File: rtl/opreq_gen.sv
module opreq_gen
    import opreq_pkg::*;
#(
    parameter int REG_NUM  = 32,
    parameter int XER_W    = 64,
    parameter int SO_BIT   = 32,
    parameter int CA_BIT   = 34,
    parameter int CA32_BIT = 45,
    localparam int IDX_W   = $clog2(REG_NUM)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               issue,
    input  logic               rd1_ok,
    input  logic [IDX_W-1:0]   rd1_num,
    input  logic               rd2_ok,
    input  logic [IDX_W-1:0]   rd2_num,
    input  logic               imm_sel,
    input  logic               oe,
    input  logic               carry_use,
    input  logic [3:0]         ack,
    output logic               ra_valid,
    output logic [REG_NUM-1:0] ra_sel,
    output logic               rb_valid,
    output logic [REG_NUM-1:0] rb_sel,
    output logic               so_valid,
    output logic [XER_W-1:0]   so_sel,
    output logic               ca_valid,
    output logic [XER_W-1:0]   ca_sel,
    output logic [3:0]         req
);
    logic [NUM_PORTS-1:0] need;

    opreq_decode #(
        .REG_NUM (REG_NUM),
        .XER_W   (XER_W),
        .SO_BIT  (SO_BIT),
        .CA_BIT  (CA_BIT),
        .CA32_BIT(CA32_BIT)
    ) u_decode (
        .rd1_ok   (rd1_ok),
        .rd1_num  (rd1_num),
        .rd2_ok   (rd2_ok),
        .rd2_num  (rd2_num),
        .imm_sel  (imm_sel),
        .oe       (oe),
        .carry_use(carry_use),
        .need     (need),
        .ra_sel   (ra_sel),
        .rb_sel   (rb_sel),
        .so_sel   (so_sel),
        .ca_sel   (ca_sel)
    );

    assign ra_valid = need[P_RA];
    assign rb_valid = need[P_RB];
    assign so_valid = need[P_SO];
    assign ca_valid = need[P_CA];

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        opreq_port_fsm u_fsm (
            .clk  (clk),
            .rst_n(rst_n),
            .issue(issue),
            .need (need[g]),
            .ack  (ack[g]),
            .req  (req[g])
        );
    end

    AST_RA_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        rd1_ok |-> $onehot0(ra_sel) && ra_sel[rd1_num]);  // R1
    AST_IMM_BLOCKS_RB: assert property (@(posedge clk) disable iff (!rst_n)
        imm_sel |-> (!rb_valid && rb_sel == '0));  // R3
    AST_IMM_NO_RB_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && imm_sel && !req[P_RB]) |=> !req[P_RB]);  // R3
    AST_CA_TWO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        carry_use |-> ($countones(ca_sel) == 2));  // R5
    AST_ZERO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        !so_valid |-> (so_sel == '0));  // R6
endmodule

// File: tb/test_opreq_gen.sv
module test_opreq_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic        rd1_ok = 1'b0;
    logic [4:0]  rd1_num = '0;
    logic        rd2_ok = 1'b0;
    logic [4:0]  rd2_num = '0;
    logic        imm_sel = 1'b0;
    logic        oe = 1'b0;
    logic        carry_use = 1'b0;
    logic [3:0]  ack = '0;
    logic        ra_valid, rb_valid, so_valid, ca_valid;
    logic [31:0] ra_sel, rb_sel;
    logic [63:0] so_sel, ca_sel;
    logic [3:0]  req;

    int n_cmp = 0;
    int n_bad = 0;

    localparam logic [63:0] SO_EXP = 64'h1 << 32;
    localparam logic [63:0] CA_EXP = (64'h1 << 34) | (64'h1 << 45);

    always #10 clk = ~clk;  // 50 MHz

    opreq_gen i_opreq_gen (
        .clk(clk), .rst_n(rst_n), .issue(issue),
        .rd1_ok(rd1_ok), .rd1_num(rd1_num), .rd2_ok(rd2_ok), .rd2_num(rd2_num),
        .imm_sel(imm_sel), .oe(oe), .carry_use(carry_use), .ack(ack),
        .ra_valid(ra_valid), .ra_sel(ra_sel), .rb_valid(rb_valid), .rb_sel(rb_sel),
        .so_valid(so_valid), .so_sel(so_sel), .ca_valid(ca_valid), .ca_sel(ca_sel),
        .req(req)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_rec(input logic r1, input logic [4:0] n1, input logic r2,
                           input logic [4:0] n2, input logic im, input logic o, input logic c);
        rd1_ok = r1; rd1_num = n1; rd2_ok = r2; rd2_num = n2;
        imm_sel = im; oe = o; carry_use = c;
        #1;
    endtask

    task automatic pulse_issue();
        issue = 1'b1; tick(); issue = 1'b0;
    endtask

    task automatic pulse_ack(input logic [3:0] a);
        ack = a; tick(); ack = '0;
    endtask

    task automatic t_reset();
        check("R10 req after reset", 64'(req), 64'h0);
    endtask

    task automatic t_full_add();
        set_rec(1'b1, 5'd5, 1'b1, 5'd31, 1'b0, 1'b1, 1'b1);
        check("R1 ra_valid", 64'(ra_valid), 64'h1);
        check("R1 ra_sel", 64'(ra_sel), 64'h20);
        check("R2 rb_valid", 64'(rb_valid), 64'h1);
        check("R2 rb_sel", 64'(rb_sel), 64'h8000_0000);
        check("R4 so_sel", so_sel, SO_EXP);
        check("R4 so_valid", 64'(so_valid), 64'h1);
        check("R5 ca_sel", ca_sel, CA_EXP);
        check("R5 ca_valid", 64'(ca_valid), 64'h1);
        check("R7 no req before issue", 64'(req), 64'h0);
        pulse_issue();
        check("R7 all ports requested", 64'(req), 64'hF);
        tick();
        check("R8 held without ack", 64'(req), 64'hF);
        pulse_ack(4'b0101);
        check("R8 partial ack", 64'(req), 64'hA);
        pulse_ack(4'b1010);
        check("R8 rest acked", 64'(req), 64'h0);
    endtask

    task automatic t_immediate();
        set_rec(1'b1, 5'd0, 1'b1, 5'd9, 1'b1, 1'b0, 1'b0);
        check("R3 rb_valid with imm", 64'(rb_valid), 64'h0);
        check("R3 rb_sel with imm", 64'(rb_sel), 64'h0);
        check("R1 ra_sel reg0", 64'(ra_sel), 64'h1);
        check("R6 so_sel zero", so_sel, 64'h0);
        check("R6 ca_sel zero", ca_sel, 64'h0);
        pulse_issue();
        check("R3 no RB request", 64'(req), 64'h1);
        pulse_ack(4'b0001);
        check("R8 RA retired", 64'(req), 64'h0);
    endtask

    task automatic t_negate();
        set_rec(1'b1, 5'd17, 1'b0, 5'd3, 1'b0, 1'b0, 1'b0);
        check("R6 rb_sel zero", 64'(rb_sel), 64'h0);
        pulse_issue();
        check("R7 negate RA only", 64'(req), 64'h1);
        pulse_ack(4'b0001);
        check("R8 negate retired", 64'(req), 64'h0);
    endtask

    task automatic t_no_issue();
        set_rec(1'b1, 5'd2, 1'b1, 5'd4, 1'b0, 1'b1, 1'b1);
        tick(); tick();
        check("R7 valid without issue", 64'(req), 64'h0);
    endtask

    task automatic t_pending();
        set_rec(1'b1, 5'd1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0);
        pulse_issue();
        check("R7 RA pending", 64'(req), 64'h1);
        set_rec(1'b1, 5'd1, 1'b1, 5'd2, 1'b0, 1'b1, 1'b1);
        pulse_issue();
        check("R9 others launch", 64'(req), 64'hF);
        pulse_ack(4'b0001);
        check("R9 single ack retires RA", 64'(req), 64'hE);
        pulse_ack(4'b1110);
        check("R8 all retired", 64'(req), 64'h0);
        pulse_ack(4'b1111);
        check("R9 idle ack ignored", 64'(req), 64'h0);
        set_rec(1'b1, 5'd1, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0);
        pulse_issue();
        check("R9 launch after idle ack", 64'(req), 64'h1);
        pulse_ack(4'b0001);
    endtask

    initial begin
        fork
            begin
                tick(); tick();
                rst_n = 1'b1;
                tick();
                t_reset();
                t_full_add();
                t_immediate();
                t_negate();
                t_no_issue();
                t_pending();
            end
            begin
                repeat (5000) @(posedge clk);
                n_cmp++;
                n_bad++;
                $display("FAIL watchdog: actual expired expected done");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule